// File: doc/BRIEF.md
# Eight-Point Forward Integer DCT Row Pass

This block performs one pass of a separable 2-D forward transform over an 8x8 tile of signed 16-bit residuals. Each accepted input row of eight samples is put through an 8-point integer DCT built from even/odd butterflies. The eight results are rounded, shifted and narrowed to 16 bits, then written as one column of an internal 8x8 buffer. When all eight rows have been taken, the buffer holds the transposed coefficient tile. It is then read out row by row, so a second, identical pass can consume it directly.

Rows enter through a valid/ready handshake. The shift amount is applied to every row and must be held stable while a tile is being filled. A one-cycle completion pulse marks the moment the tile is full. Input is refused until every output row has been taken, which keeps the single buffer from being overwritten while it drains.

Top module: `dct8_row_fwd`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: The DC and Nyquist outputs are y0 = 64·(x0+x1+…+x7) and y4 = 64·(x0−x1−x2+x3+x4−x5−x6+x7), before rounding.
- R3: With p = x0+x7−x3−x4 and q = x1+x6−x2−x5, the outputs are y2 = 84·p + 35·q and y6 = 35·p − 84·q, before rounding.
- R4: With d_j = x_j − x_(7−j), the outputs are y1 = 89d0+75d1+50d2+18d3, y3 = 75d0−18d1−89d2−50d3, y5 = 50d0−89d1+18d2+75d3 and y7 = 18d0−50d1+75d2−89d3, before rounding.
- R5: Each output becomes (y + 2^(s−1)) arithmetically shifted right by s, where s = shift_i and s ≥ 1, using 32-bit two's-complement arithmetic.
- R6: The rounded 32-bit value is narrowed by keeping its low 16 bits, with no saturation.
- R7: Input sample j of a row sits at in_row bits [16j+15:16j]. Output row k holds coefficient k of input row r at out_row bits [16r+15:16r], so the tile is transposed.
- R8: in_ready drops in the cycle after the eighth row is accepted and stays low until the eighth output row is taken. Rows presented while it is low leave the outputs unchanged.
- R9: done is high for exactly one cycle, the cycle after the eighth input row is accepted, and coincides with the first cycle of out_valid.
- R10: Output rows appear in order 0 to 7. While out_valid is high and out_ready is low, out_row holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_i | input | 5 | Rounding shift amount, at least 1 |
| in_valid | input | 1 | Input row is present |
| in_ready | output | 1 | Block accepts an input row |
| in_row | input | 128 | Eight signed 16-bit samples |
| out_valid | output | 1 | Output row is present |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | 128 | Eight signed 16-bit coefficients |
| done | output | 1 | Tile complete pulse |

## Verification
The hardest situations to reach are wraparound on narrowing and exact half-way rounding of negative values. Neither arises from typical residuals. The stimulus therefore includes a tile of full-scale rows with a shift of 1, which drives the DC term far past 16 bits. It also includes a tile of unit impulses with a shift of 7, where several products land exactly on the rounding boundary. A further tile keeps in_valid asserted with junk data through the whole drain while out_ready stalls in a fixed pattern. This exercises the refusal of input and the holding of output rows together.

// File: rtl/dct8_row_fwd.sv
module dct8_row_fwd #(
  parameter int DW  = 16,
  parameter int SHW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SHW-1:0]    shift_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [8*DW-1:0]   in_row,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [8*DW-1:0]   out_row,
  output logic              done
);
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int AW = 32;
  localparam int signed OC [4][4] = '{'{89, 75, 50, 18}, '{75, -18, -89, -50},
                                      '{50, -89, 18, 75}, '{18, -50, 75, -89}};

  logic signed [AW-1:0] x [N];
  logic signed [AW-1:0] e [4];
  logic signed [AW-1:0] o [4];
  logic signed [AW-1:0] ee0, ee1, eo0, eo1, rnd, acc, t;
  logic signed [AW-1:0] y [N];
  logic [DW-1:0] z [N];
  logic [DW-1:0] tbuf [N][N];
  logic [IW-1:0] cnt;
  logic drain;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;
  wire last = (cnt == IW'(N-1));

  assign in_ready  = !drain;
  assign out_valid = drain;

  always_comb begin
    for (int j = 0; j < N; j++) x[j] = AW'($signed(in_row[j*DW +: DW]));
    for (int j = 0; j < 4; j++) begin
      e[j] = x[j] + x[N-1-j];
      o[j] = x[j] - x[N-1-j];
    end
    ee0 = e[0] + e[3];
    ee1 = e[1] + e[2];
    eo0 = e[0] - e[3];
    eo1 = e[1] - e[2];
    y[0] = 64 * (ee0 + ee1);
    y[4] = 64 * (ee0 - ee1);
    y[2] = 84 * eo0 + 35 * eo1;
    y[6] = 35 * eo0 - 84 * eo1;
    acc = '0;
    for (int m = 0; m < 4; m++) begin
      acc = '0;
      for (int j = 0; j < 4; j++) acc = acc + OC[m][j] * o[j];
      y[2*m+1] = acc;
    end
    rnd = 32'sd1 <<< (shift_i - SHW'(1));
    t = '0;
    for (int k = 0; k < N; k++) begin
      t = (y[k] + rnd) >>> shift_i;
      z[k] = t[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      drain <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= take && last;
      if (take || give) cnt <= cnt + 1'b1;
      if (take && last) drain <= 1'b1;
      if (give && last) drain <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take)
      for (int k = 0; k < N; k++) tbuf[k][cnt] <= z[k];
  end

  always_comb begin
    for (int r = 0; r < N; r++) out_row[r*DW +: DW] = tbuf[cnt][r];
  end

  // R5
  shift_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> shift_i >= SHW'(1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !in_ready);
endmodule

// File: tb/dct8_row_fwd_test.sv
module dct8_row_fwd_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [4:0] shift_i = 5'd2;
  logic in_valid = 0, out_ready = 0;
  logic [127:0] in_row = '0;
  logic in_ready, out_valid, done;
  logic [127:0] out_row;

  int checks = 0, failures = 0;

  dct8_row_fwd uut (.clk(clk), .rst_n(rst_n), .shift_i(shift_i), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int basis(int k, int j);
    int h, v;
    int od [4][4] = '{'{89,75,50,18}, '{75,-18,-89,-50}, '{50,-89,18,75}, '{18,-50,75,-89}};
    int c2 [4] = '{84, 35, -35, -84};
    int c6 [4] = '{35, -84, 84, -35};
    h = (j < 4) ? j : 7 - j;
    if (k % 2 == 1) begin
      v = od[(k-1)/2][h];
      return (j < 4) ? v : -v;
    end
    case (k)
      0: return 64;
      4: return (h == 0 || h == 3) ? 64 : -64;
      2: return c2[h];
      default: return c6[h];
    endcase
  endfunction

  function automatic logic [15:0] coef(logic [127:0] row, int k, int sh);
    int s;
    s = 0;
    for (int j = 0; j < 8; j++) s += basis(k, j) * int'($signed(row[16*j +: 16]));
    s = (s + (1 <<< (sh - 1))) >>> sh;
    return s[15:0];
  endfunction

  // reference model
  logic m_ready = 1, m_valid = 0, m_done = 0;
  int icnt = 0, ocnt = 0;
  logic [15:0] exp_m [8][8];
  string stim_tag = "", m_tag = "";

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 0;
      if (m_valid && out_ready) begin
        ocnt++;
        if (ocnt == 8) begin ocnt = 0; m_valid = 0; m_ready = 1; end
      end else if (m_ready && in_valid) begin
        for (int k = 0; k < 8; k++) exp_m[k][icnt] = coef(in_row, k, int'(shift_i));
        icnt++;
        if (icnt == 8) begin
          icnt = 0; m_ready = 0; m_valid = 1; m_done = 1; m_tag = stim_tag;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  logic stall_en = 0;
  logic prev_stall = 0;
  logic [127:0] prev_row = '0;
  int cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(in_ready == m_ready, "R8 in_ready", {127'd0, in_ready}, {127'd0, m_ready});
      chk(out_valid == m_valid, "R10 out_valid", {127'd0, out_valid}, {127'd0, m_valid});
      chk(done == m_done, "R9 done", {127'd0, done}, {127'd0, m_done});
      if (prev_stall)
        chk(out_row == prev_row, "R10 hold", out_row, prev_row);
      if (out_valid && m_valid) begin
        for (int r = 0; r < 8; r++) begin
          string tg;
          if (m_tag != "") tg = m_tag;
          else if (ocnt == 0 || ocnt == 4) tg = "R2";
          else if (ocnt == 2 || ocnt == 6) tg = "R3";
          else tg = "R4";
          chk(out_row[16*r +: 16] == exp_m[ocnt][r],
              $sformatf("%s (R7 position row %0d col %0d)", tg, ocnt, r),
              {112'd0, out_row[16*r +: 16]}, {112'd0, exp_m[ocnt][r]});
        end
      end
      out_ready = stall_en ? (cyc % 4 != 1) : 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_row = out_row;
    end
  end

  task automatic send_block(logic [127:0] rows [8], int sh, string tag, bit junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    stim_tag = tag;
    shift_i = 5'(sh);
    for (int r = 0; r < 8; r++) begin
      in_valid = 1; in_row = rows[r];
      @(negedge clk);
      while (!in_ready) @(negedge clk);
    end
    in_valid = 0;
    @(negedge clk);
    while (!in_ready) begin
      if (junk) begin in_valid = 1; in_row = {8{16'h5A5A}}; end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [127:0] rows [8];
    repeat (2) @(posedge clk);
    #1;
    // R1
    chk(in_ready == 1 && out_valid == 0 && done == 0, "R1 reset",
        {125'd0, in_ready, out_valid, done}, {125'd0, 3'b100});
    @(negedge clk); rst_n = 1;

    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++)
        rows[r][16*j +: 16] = 16'((r * 373 + j * 1111 + r * j * 57) % 2001 - 1000);
    send_block(rows, 2, "", 0);

    stall_en = 1;
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++)
        rows[r][16*j +: 16] = 16'((j == r) ? 900 - r * 250 : (r - j) * 31);
    send_block(rows, 3, "", 1);

    // R6: full-scale rows overflow 16 bits
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++)
        rows[r][16*j +: 16] = (r % 2 == 0) ? 16'h7FFF :
                              (((j + r) % 2 == 0) ? 16'h8000 : 16'h7FFF);
    send_block(rows, 1, "R6", 0);

    // R5: impulses land on rounding boundaries
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++)
        rows[r][16*j +: 16] = (j == r) ? 16'((r % 2 == 0) ? 1 : -1) : 16'd0;
    send_block(rows, 7, "R5", 1);

    stall_en = 0;
    for (int r = 0; r < 8; r++)
      for (int j = 0; j < 8; j++)
        rows[r][16*j +: 16] = 16'(-(r + 1) * (j + 3) * 97);
    send_block(rows, 4, "", 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule